// File: doc/BRIEF.md
# Dual-Port Parallel Interface Adapter

This block is a bus-attached peripheral with two bidirectional parallel ports, A and B. Each port has an output register, a direction register and a control register. Each side also has two handshake lines. C1 is always an input. C2 can be set up as an input or as an output. A processor reaches the block through a two-bit slot select, a chip-select and a read/write flag, all sampled on one clock edge. A read returns its data combinationally in the same cycle. Its side effects take place at the end of that cycle.

The output register and the direction register of a port share one slot. A bit in that port's control register picks which of the two the slot reaches. The C1 and C2 inputs pass through synchronizers. On the configured edge of either line, a flag is latched, and it can drive an active-low interrupt. A read of a port's output register clears that side's flags.

On port A, C2 can act as a read strobe. A read of the port A output register pulls it low. It then either returns high one cycle later or waits for the next active edge on C1. A static input can swap the slot ordering.

Top module: `dual_port_adapter`

## Requirements
- R1: After reset, all registers are zero. Both direction outputs are 0 and both interrupt outputs are high. Neither C2 line is driven (`ca2_oe`/`cb2_oe` low), and reading slot 0 returns 0x00.
- R2: When `swap_order`=0, the slot select maps 0 to port A data, 1 to port A control, 2 to port B data and 3 to port B control. When `swap_order`=1, it maps 0 to A data, 1 to B data, 2 to A control and 3 to B control.
- R3: Control bit 2 picks which register the data slot reaches for both reads and writes: 1 means the output register, 0 means the direction register.
- R4: A port data read returns each bit from the output register where the direction bit is 1, and from the pin input where it is 0.
- R5: Control bit 1 picks the active C1 edge (1 = rising, 0 = falling). That edge sets the C1 flag, which reads back in control bit 7. When control bit 0 is 1, the interrupt output goes low while the flag is set.
- R6: When control bit 5 is 0, C2 is an input. Bit 4 then picks its edge (1 = rising) and bit 3 enables its interrupt. The C2 flag reads back in bit 6 only while C2 is an input, and it drives no interrupt otherwise.
- R7: A read of the output register clears both flags of that side and releases its interrupt. A read of the direction register leaves the flags alone.
- R8: Port A control bits 5..3 = 100 select read-strobe mode with restore on C1. A port A output-register read drives `ca2_out` low, and it stays low until the next active C1 edge.
- R9: Port A control bits 5..3 = 101 select read-strobe mode with immediate restore. A port A output-register read drives `ca2_out` low for exactly one cycle.
- R10: When control bits 5..4 = 11, the C2 output follows control bit 3.
- R11: On port B, reads never change `cb2_out`. In modes 100 and 101 it holds high.
- R12: `rdata` is zero unless a read access is present. A control read returns the stored bits 5..0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Access strobe for this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| swap_order | input | 1 | Selects the alternate slot ordering |
| sel | input | 2 | Slot select |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, zero when idle |
| pa_in | input | DW | Port A pin input |
| pa_out | output | DW | Port A output register |
| pa_dir | output | DW | Port A direction (1 = output) |
| ca1 | input | 1 | Port A C1 line |
| ca2_in | input | 1 | Port A C2 line when it is an input |
| ca2_out | output | 1 | Port A C2 drive level |
| ca2_oe | output | 1 | Port A C2 output enable |
| irqa_n | output | 1 | Port A interrupt, active low |
| pb_in | input | DW | Port B pin input |
| pb_out | output | DW | Port B output register |
| pb_dir | output | DW | Port B direction (1 = output) |
| cb1 | input | 1 | Port B C1 line |
| cb2_in | input | 1 | Port B C2 line when it is an input |
| cb2_out | output | 1 | Port B C2 drive level |
| cb2_oe | output | 1 | Port B C2 output enable |
| irqb_n | output | 1 | Port B interrupt, active low |

## Verification
The hardest case to reach is a pending flag that must survive while the shared slot points at the direction register. It can only be observed by reading the direction register, confirming that the interrupt stays low, and then switching the slot back before the clearing read. The stimulus sets this up by raising C1 under an enabled edge. It then rewrites the control register with bit 2 cleared, reads the direction register and samples the interrupt pin. A second hard case is a C2 flag hidden by a switch to output mode without any read. The bench raises the port B C2 input, rewrites the control register into output mode, and confirms that bit 6 disappears from the readback.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    // Number of ports (A and B)
    localparam int NSIDES = 2;

    // Stored control bits 5..0; bits 7..6 are read-only flags
    typedef struct packed {
        logic       c2_drive;   // bit 5: C2 is an output
        logic [1:0] c2_mode;    // bits 4..3: C2 mode / edge+enable
        logic       data_sel;   // bit 2: slot reaches output register
        logic       c1_rise;    // bit 1: C1 active edge is rising
        logic       c1_en;      // bit 0: C1 interrupt enable
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Decoded slot: which side and whether it is the control slot
    typedef struct packed {
        logic side;
        logic is_ctl;
    } slot_t;

    function automatic slot_t map_slot(input logic [1:0] sel, input logic swap);
        slot_t s;
        if (swap) begin
            s.side   = sel[0];
            s.is_ctl = sel[1];
        end else begin
            s.side   = sel[1];
            s.is_ctl = sel[0];
        end
        return s;
    endfunction

endpackage

// File: rtl/dpa_edge_sync.sv
module dpa_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], pin};
        end
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/dpa_side.sv
module dpa_side
    import dpa_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit HAS_RSTROBE = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_data,
    input  logic          acc_ctl,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pin_in,
    input  logic          c1_pin,
    input  logic          c2_pin,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] rd_ctl,
    output logic [DW-1:0] port_out,
    output logic [DW-1:0] port_dir,
    output logic          c2_out,
    output logic          c2_oe,
    output logic          irq_n
);
    ctl_t          ctl_q;
    logic [DW-1:0] out_q;
    logic [DW-1:0] dir_q;
    logic          f1_q;
    logic          f2_q;
    logic          c2_lvl;

    logic c1_rise, c1_fall, c2_rise, c2_fall;

    dpa_edge_sync #(.STAGES(SYNC_STAGES)) u_c1 (
        .clk(clk), .rst(rst), .pin(c1_pin), .rise(c1_rise), .fall(c1_fall)
    );
    dpa_edge_sync #(.STAGES(SYNC_STAGES)) u_c2 (
        .clk(clk), .rst(rst), .pin(c2_pin), .rise(c2_rise), .fall(c2_fall)
    );

    logic c2_is_in, c1_hit, c2_hit, rd_port, wr_ctl, wr_data;
    assign c2_is_in = ~ctl_q.c2_drive;
    assign c1_hit   = ctl_q.c1_rise ? c1_rise : c1_fall;
    assign c2_hit   = c2_is_in & (ctl_q.c2_mode[1] ? c2_rise : c2_fall);
    assign rd_port  = acc_data & ~wr & ctl_q.data_sel;
    assign wr_ctl   = acc_ctl & wr;
    assign wr_data  = acc_data & wr;

    wire unused_hi = ^wdata[DW-1:CTL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            out_q <= '0;
            dir_q <= '0;
            f1_q  <= 1'b0;
            f2_q  <= 1'b0;
        end else begin
            if (wr_ctl) ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
            if (wr_data && ctl_q.data_sel)  out_q <= wdata;
            if (wr_data && !ctl_q.data_sel) dir_q <= wdata;
            // a new edge wins over a clearing read in the same cycle
            if (c1_hit)       f1_q <= 1'b1;
            else if (rd_port) f1_q <= 1'b0;
            if (c2_hit)       f2_q <= 1'b1;
            else if (rd_port) f2_q <= 1'b0;
        end
    end

    generate
        if (HAS_RSTROBE) begin : g_rstrobe
            logic strobe_mode;
            assign strobe_mode = ctl_q.c2_drive & ~ctl_q.c2_mode[1];
            always_ff @(posedge clk) begin
                if (rst) begin
                    c2_lvl <= 1'b1;
                end else if (!strobe_mode) begin
                    c2_lvl <= 1'b1;
                end else if (rd_port) begin
                    c2_lvl <= 1'b0;
                end else if (ctl_q.c2_mode[0] || c1_hit) begin
                    c2_lvl <= 1'b1;
                end
            end
        end else begin : g_nostrobe
            assign c2_lvl = 1'b1;
        end
    endgenerate

    assign c2_out = ctl_q.c2_mode[1] ? ctl_q.c2_mode[0] : c2_lvl;
    assign c2_oe  = ctl_q.c2_drive;
    assign irq_n  = ~((f1_q & ctl_q.c1_en) | (f2_q & c2_is_in & ctl_q.c2_mode[0]));

    assign rd_data  = ctl_q.data_sel ? ((out_q & dir_q) | (pin_in & ~dir_q)) : dir_q;
    assign port_out = out_q;
    assign port_dir = dir_q;

    always_comb begin
        rd_ctl              = '0;
        rd_ctl[CTL_W-1:0]   = ctl_q;
        rd_ctl[CTL_W+1]     = f1_q;
        rd_ctl[CTL_W]       = f2_q & c2_is_in;
    end
endmodule

// File: rtl/dual_port_adapter.sv
module dual_port_adapter
    import dpa_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs,
    input  logic          wr,
    input  logic          swap_order,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_dir,
    input  logic          ca1,
    input  logic          ca2_in,
    output logic          ca2_out,
    output logic          ca2_oe,
    output logic          irqa_n,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_dir,
    input  logic          cb1,
    input  logic          cb2_in,
    output logic          cb2_out,
    output logic          cb2_oe,
    output logic          irqb_n
);
    slot_t slot;
    assign slot = map_slot(sel, swap_order);

    logic [DW-1:0] s_pin  [NSIDES];
    logic [DW-1:0] s_out  [NSIDES];
    logic [DW-1:0] s_dir  [NSIDES];
    logic [DW-1:0] s_rdd  [NSIDES];
    logic [DW-1:0] s_rdc  [NSIDES];
    logic [NSIDES-1:0] s_c1, s_c2i, s_c2o, s_c2e, s_irq;

    assign s_pin[0] = pa_in;
    assign s_pin[1] = pb_in;
    assign s_c1     = {cb1, ca1};
    assign s_c2i    = {cb2_in, ca2_in};

    generate
        for (genvar i = 0; i < NSIDES; i++) begin : g_side
            logic acc_d, acc_c;
            assign acc_d = cs & (slot.side == 1'(i)) & ~slot.is_ctl;
            assign acc_c = cs & (slot.side == 1'(i)) &  slot.is_ctl;
            dpa_side #(
                .DW(DW), .SYNC_STAGES(SYNC_STAGES), .HAS_RSTROBE(i == 0)
            ) u_side (
                .clk(clk), .rst(rst),
                .acc_data(acc_d), .acc_ctl(acc_c), .wr(wr), .wdata(wdata),
                .pin_in(s_pin[i]), .c1_pin(s_c1[i]), .c2_pin(s_c2i[i]),
                .rd_data(s_rdd[i]), .rd_ctl(s_rdc[i]),
                .port_out(s_out[i]), .port_dir(s_dir[i]),
                .c2_out(s_c2o[i]), .c2_oe(s_c2e[i]), .irq_n(s_irq[i])
            );
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (cs && !wr) begin
            rdata = slot.is_ctl ? s_rdc[slot.side] : s_rdd[slot.side];
        end
    end

    assign pa_out  = s_out[0];
    assign pa_dir  = s_dir[0];
    assign pb_out  = s_out[1];
    assign pb_dir  = s_dir[1];
    assign ca2_out = s_c2o[0];
    assign ca2_oe  = s_c2e[0];
    assign cb2_out = s_c2o[1];
    assign cb2_oe  = s_c2e[1];
    assign irqa_n  = s_irq[0];
    assign irqb_n  = s_irq[1];
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cs,
    input logic          wr,
    input logic [DW-1:0] pa_dir,
    input logic [DW-1:0] pb_dir,
    input logic          ca2_out,
    input logic          ca2_oe,
    input logic          cb2_out,
    input logic          cb2_oe,
    input logic          irqa_n,
    input logic          irqb_n
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pa_dir == '0 && pb_dir == '0 && irqa_n && irqb_n && !ca2_oe && !cb2_oe)); // R1

    AST_DIR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(pa_dir) |-> $past(cs && wr)); // R3

    AST_IRQ_RELEASE_BY_ACCESS: assert property (@(posedge clk) disable iff (rst)
        $rose(irqa_n) |-> $past(cs)); // R7

    AST_CA2_FALL_BY_ACCESS: assert property (@(posedge clk) disable iff (rst)
        $fell(ca2_out) |-> $past(cs)); // R8

    AST_CB2_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(cb2_out) |-> $past(cs && wr)); // R11
endmodule

bind dual_port_adapter dpa_checker #(.DW(DW)) u_chk (.*);

// File: tb/dual_port_adapter_tb.sv
`timescale 1ns/100ps
module dual_port_adapter_tb;
    localparam int DW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, cs, wr, swap_order;
    logic [1:0] sel;
    logic [DW-1:0] wdata, rdata, pa_in, pa_out, pa_dir, pb_in, pb_out, pb_dir;
    logic ca1, ca2_in, ca2_out, ca2_oe, irqa_n;
    logic cb1, cb2_in, cb2_out, cb2_oe, irqb_n;

    dual_port_adapter #(.DW(DW)) u_dut (
        .clk(clk), .rst(rst), .cs(cs), .wr(wr), .swap_order(swap_order),
        .sel(sel), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir),
        .ca1(ca1), .ca2_in(ca2_in), .ca2_out(ca2_out), .ca2_oe(ca2_oe), .irqa_n(irqa_n),
        .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir),
        .cb1(cb1), .cb2_in(cb2_in), .cb2_out(cb2_out), .cb2_oe(cb2_oe), .irqb_n(irqb_n)
    );

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } item_t;

    item_t exp_q[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: compares every read cycle against the scoreboard
    always @(negedge clk) begin
        #1;
        if (cs && !wr) begin
            if (exp_q.size() == 0) begin
                chk(rdata, 'x, "scoreboard empty");
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(rdata, it.exp, it.tag);
            end
        end
    end

    task automatic bus_wr(input logic [1:0] s, input logic [DW-1:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] s, input logic [DW-1:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        cs = 1'b1; wr = 1'b0; sel = s;
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; cs = 1'b0; wr = 1'b0; swap_order = 1'b0; sel = '0; wdata = '0;
        pa_in = 8'hA5; pb_in = 8'h66;
        ca1 = 1'b0; ca2_in = 1'b0; cb1 = 1'b0; cb2_in = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle(1);

        // R1: reset state
        chk(pa_dir, 8'h00, "R1 pa_dir");
        chk({6'b0, irqa_n, irqb_n}, 8'h03, "R1 irq high");
        chk({6'b0, ca2_oe, cb2_oe}, 8'h00, "R1 C2 undriven");
        bus_rd(2'd0, 8'h00, "R1 slot0 read");
        bus_rd(2'd1, 8'h00, "R1 ctl A read");

        // R3: shared slot selection
        bus_wr(2'd0, 8'hF0);
        settle(0);
        chk(pa_dir, 8'hF0, "R3 dir write");
        bus_wr(2'd1, 8'h04);
        bus_wr(2'd0, 8'h3C);
        settle(0);
        chk(pa_out, 8'h3C, "R3 out write");
        chk(pa_dir, 8'hF0, "R3 dir untouched");
        // R4: mixed read
        bus_rd(2'd0, 8'h35, "R4 port A mix");
        bus_rd(2'd1, 8'h04, "R12 ctl readback");

        // R2: port B slots, default and swapped
        bus_wr(2'd3, 8'h04);
        bus_wr(2'd2, 8'h81);
        settle(0);
        chk(pb_out, 8'h81, "R2 B data slot");
        bus_rd(2'd2, 8'h66, "R4 port B all inputs");
        swap_order = 1'b1;
        bus_wr(2'd1, 8'h0F);
        settle(0);
        chk(pb_out, 8'h0F, "R2 swapped B data");
        bus_rd(2'd2, 8'h04, "R2 swapped A ctl");
        swap_order = 1'b0;

        // R5: C1 rising edge with enable
        bus_wr(2'd1, 8'h07);
        ca1 = 1'b1;
        settle(5);
        chk({7'b0, irqa_n}, 8'h00, "R5 irqa low");
        bus_rd(2'd1, 8'h87, "R5 flag bit7");
        bus_rd(2'd0, 8'h35, "R7 clearing read");
        settle(0);
        chk({7'b0, irqa_n}, 8'h01, "R7 irqa released");
        bus_rd(2'd1, 8'h07, "R7 flag cleared");

        // R7: direction read keeps flags
        ca1 = 1'b0;
        settle(5);
        chk({7'b0, irqa_n}, 8'h01, "R5 inactive edge ignored");
        ca1 = 1'b1;
        settle(5);
        bus_wr(2'd1, 8'h03);
        bus_rd(2'd0, 8'hF0, "R7 dir read");
        settle(0);
        chk({7'b0, irqa_n}, 8'h00, "R7 flag kept on dir read");
        bus_wr(2'd1, 8'h07);
        bus_rd(2'd0, 8'h35, "R7 clear again");
        settle(0);
        chk({7'b0, irqa_n}, 8'h01, "R7 released again");

        // R5: falling edge
        bus_wr(2'd1, 8'h05);
        ca1 = 1'b0;
        settle(5);
        chk({7'b0, irqa_n}, 8'h00, "R5 falling edge");
        bus_rd(2'd0, 8'h35, "R7 clear falling");

        // R6: C2 input on port B
        bus_wr(2'd3, 8'h1C);
        cb2_in = 1'b1;
        settle(5);
        chk({7'b0, irqb_n}, 8'h00, "R6 irqb low");
        bus_rd(2'd3, 8'h5C, "R6 flag bit6");
        bus_wr(2'd3, 8'h3C);
        bus_rd(2'd3, 8'h3C, "R6 flag hidden as output");
        settle(0);
        chk({7'b0, irqb_n}, 8'h01, "R6 no irq as output");
        // R10: manual level
        chk({6'b0, cb2_oe, cb2_out}, 8'h03, "R10 cb2 high");
        bus_wr(2'd3, 8'h34);
        settle(0);
        chk({6'b0, cb2_oe, cb2_out}, 8'h02, "R10 cb2 low");

        // R11: no strobe on port B
        bus_wr(2'd3, 8'h24);
        settle(0);
        chk({7'b0, cb2_out}, 8'h01, "R11 cb2 idle high");
        bus_rd(2'd2, 8'h66, "R11 port B read");
        #0;
        chk({7'b0, cb2_out}, 8'h01, "R11 cb2 after read");
        settle(1);
        chk({7'b0, cb2_out}, 8'h01, "R11 cb2 later");

        // R8: strobe held until C1 rising edge
        bus_wr(2'd1, 8'h26);
        settle(0);
        chk({6'b0, ca2_oe, ca2_out}, 8'h03, "R8 ca2 idle high");
        bus_rd(2'd0, 8'h35, "R8 strobe read");
        #1;
        chk({7'b0, ca2_out}, 8'h00, "R8 ca2 low");
        settle(3);
        chk({7'b0, ca2_out}, 8'h00, "R8 ca2 held low");
        ca1 = 1'b1;
        settle(5);
        chk({7'b0, ca2_out}, 8'h01, "R8 ca2 restored by C1");

        // R9: one-cycle strobe
        bus_wr(2'd1, 8'h2C);
        bus_rd(2'd0, 8'h35, "R9 strobe read");
        #1;
        chk({7'b0, ca2_out}, 8'h00, "R9 ca2 low one cycle");
        settle(1);
        chk({7'b0, ca2_out}, 8'h01, "R9 ca2 back high");

        // R12: idle bus
        settle(1);
        chk(rdata, 8'h00, "R12 idle rdata");

        settle(2);
        done = 1'b1;
        finish_run();
    end
endmodule